// File: doc/BRIEF.md
# Dual-Port Semaphore and Mailbox Signalling Unit

This unit sits beside a two-port shared memory and gives the two sides a way to coordinate. It does not store memory data. It watches each port's select, direction, output-enable, address and write-data pins on every clock cycle, and it provides two services.

The first is a bank of eight hardware lock flags. Either port can request a flag, release it, or read whether it holds it. The second is a pair of mailbox interrupts. When one port writes to its doorbell word, the opposite port's interrupt goes up. That interrupt stays up until the receiving port reads its acknowledge word.

Each clock cycle in which a port's pins decode to an operation counts as exactly one access. The read-back of a flag appears one cycle later, marked by a single-cycle valid strobe. The unit has no back-pressure: the strobe never stalls, and the receiver must take the word in the cycle it is presented.

Top module: `dp_signal_hub`

## Requirements
- R1: After reset, both interrupt outputs are low, both read-valid strobes are low, and all eight flags are unowned.
- R2: A port reaches flag space only when its memory select (`x_cs_n`) is high and its flag select (`x_sem_n`) is low. Memory-space accesses need `x_cs_n` low and `x_sem_n` high. With both selects low, nothing changes: no flag, no interrupt, no read strobe.
- R3: A flag write is one with `x_rw_n`=0. The written value is the AND of write-data bits 0, 8, 16 and 24, and the flag is picked by address bits [2:0]. A value of 0 records a request from that port. A value of 1 withdraws that port's request, and releases the flag if that port owns it.
- R4: An unowned flag with a pending request goes to the requester at the same clock edge. A flag never has two owners.
- R5: When both ports request the same unowned flag on the same edge, port A wins. Port B's request stays pending.
- R6: A pending request takes the flag at the edge where the current owner releases it.
- R7: A release written by the port that does not own the flag leaves the owner unchanged.
- R8: A flag read is one with `x_rw_n`=1 and `x_oe_n`=0. One cycle later, `x_rvalid` pulses and `x_rdata` holds the flag value on bits 0, 8, 16 and 24: 0 if the reader owns the flag, 1 otherwise. All other bits are 0. A read made in the cycle right after a write sees the result of that write.
- R9: A memory-space write (`x_rw_n`=0) to the all-ones address raises the opposite port's interrupt on the next edge. The two ports behave the same way.
- R10: A memory-space read (`x_rw_n`=1, `x_oe_n`=0) by the interrupted port of the all-ones-minus-one address clears its interrupt on the next edge. If a set and a clear land on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_cs_n | input | 1 | Port A memory select, active low |
| a_sem_n | input | 1 | Port A flag-space select, active low |
| a_rw_n | input | 1 | Port A direction, 1 read / 0 write |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_addr | input | AW | Port A address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A flag read-back word |
| a_rvalid | output | 1 | Port A read-back strobe |
| a_irq | output | 1 | Port A mailbox interrupt |
| b_cs_n | input | 1 | Port B memory select, active low |
| b_sem_n | input | 1 | Port B flag-space select, active low |
| b_rw_n | input | 1 | Port B direction, 1 read / 0 write |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_addr | input | AW | Port B address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B flag read-back word |
| b_rvalid | output | 1 | Port B read-back strobe |
| b_irq | output | 1 | Port B mailbox interrupt |

## Verification
The bench goes after the cases where flag ownership changes hands:
- Simultaneous claims: a design that got these wrong would grant both ports, or drop port B's pending request.
- A release with a waiting requester: a wrong design would leave the flag idle.
- A release written by the non-owner: a wrong design would free a flag that port does not hold.

It also checks the input cases that must not act:
- Both selects low: a decoder that treats this as a flag or mailbox access would change state.
- Only one byte lane carrying the 0: a design sampling only lane 0 would miss the request.

On the mailbox side, it drives a doorbell and an acknowledge on the same edge. A design that lets the clear win would lose that interrupt.

// File: rtl/dpsig_pkg.sv
package dpsig_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } owner_e;

  typedef struct packed {
    logic sem_wr;
    logic sem_rd;
    logic wval;
    logic mb_set;
    logic mb_clr;
  } port_cmd_t;
endpackage

// File: rtl/port_decode.sv
module port_decode
  import dpsig_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 32
) (
  input  logic          cs_n,
  input  logic          sem_n,
  input  logic          rw_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output port_cmd_t     cmd
);
  localparam int LANES = DW / 8;
  localparam logic [AW-1:0] SET_ADR = '1;
  localparam logic [AW-1:0] CLR_ADR = SET_ADR - 1'b1;

  logic [LANES-1:0] lane_bit;
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_bit[l] = wdata[l*8];
  end

  logic sem_space, mem_space;
  assign sem_space = cs_n & ~sem_n;
  assign mem_space = ~cs_n & sem_n;

  always_comb begin
    cmd.sem_wr = sem_space & ~rw_n;
    cmd.sem_rd = sem_space & rw_n & ~oe_n;
    cmd.wval   = &lane_bit;
    cmd.mb_set = mem_space & ~rw_n & (addr == SET_ADR);
    cmd.mb_clr = mem_space & rw_n & ~oe_n & (addr == CLR_ADR);
  end
endmodule

// File: rtl/sem_flag.sv
module sem_flag
  import dpsig_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_a,
  input  logic   val_a,
  input  logic   wr_b,
  input  logic   val_b,
  output owner_e owner
);
  logic   req_a, req_b, req_a_n, req_b_n;
  owner_e own_n;

  always_comb begin
    req_a_n = wr_a ? ~val_a : req_a;
    req_b_n = wr_b ? ~val_b : req_b;
    own_n   = owner;
    if (owner == OWN_A && !req_a_n) own_n = OWN_NONE;
    if (owner == OWN_B && !req_b_n) own_n = OWN_NONE;
    if (own_n == OWN_NONE) begin
      if (req_a_n)      own_n = OWN_A;
      else if (req_b_n) own_n = OWN_B;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_a <= 1'b0;
      req_b <= 1'b0;
      owner <= OWN_NONE;
    end else begin
      req_a <= req_a_n;
      req_b <= req_b_n;
      owner <= own_n;
    end
  end

  // R4
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owner != 2'd3);
  // R5
  tie_goes_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_NONE && wr_a && !val_a && wr_b && !val_b) |=> (owner == OWN_A));
  // R7
  foreign_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_A && wr_b && !wr_a) |=> (owner == OWN_A));
  // R6
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_A && req_b && !wr_b && wr_a && val_a) |=> (owner == OWN_B));
endmodule

// File: rtl/mailbox_irq.sv
module mailbox_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;
    else if (clr_i) irq_o <= 1'b0;
  end

  // R9
  raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> irq_o);
  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !irq_o);
endmodule

// File: rtl/dp_signal_hub.sv
module dp_signal_hub
  import dpsig_pkg::*;
#(
  parameter int AW   = 14,
  parameter int DW   = 32,
  parameter int NSEM = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_cs_n,
  input  logic          a_sem_n,
  input  logic          a_rw_n,
  input  logic          a_oe_n,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_rvalid,
  output logic          a_irq,
  input  logic          b_cs_n,
  input  logic          b_sem_n,
  input  logic          b_rw_n,
  input  logic          b_oe_n,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_rvalid,
  output logic          b_irq
);
  localparam int SW    = $clog2(NSEM);
  localparam int LANES = DW / 8;

  port_cmd_t cmd_a, cmd_b;
  owner_e    own [NSEM];
  logic [SW-1:0] idx_a, idx_b;

  assign idx_a = a_addr[SW-1:0];
  assign idx_b = b_addr[SW-1:0];

  port_decode #(.AW(AW), .DW(DW)) u_dec_a (
    .cs_n(a_cs_n), .sem_n(a_sem_n), .rw_n(a_rw_n), .oe_n(a_oe_n),
    .addr(a_addr), .wdata(a_wdata), .cmd(cmd_a));
  port_decode #(.AW(AW), .DW(DW)) u_dec_b (
    .cs_n(b_cs_n), .sem_n(b_sem_n), .rw_n(b_rw_n), .oe_n(b_oe_n),
    .addr(b_addr), .wdata(b_wdata), .cmd(cmd_b));

  for (genvar f = 0; f < NSEM; f++) begin : g_flag
    sem_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .wr_a(cmd_a.sem_wr && idx_a == SW'(f)), .val_a(cmd_a.wval),
      .wr_b(cmd_b.sem_wr && idx_b == SW'(f)), .val_b(cmd_b.wval),
      .owner(own[f]));
  end

  mailbox_irq u_mb_a (.clk(clk), .rst_n(rst_n),
    .set_i(cmd_b.mb_set), .clr_i(cmd_a.mb_clr), .irq_o(a_irq));
  mailbox_irq u_mb_b (.clk(clk), .rst_n(rst_n),
    .set_i(cmd_a.mb_set), .clr_i(cmd_b.mb_clr), .irq_o(b_irq));

  function automatic logic [DW-1:0] flag_word(input logic mine);
    logic [DW-1:0] w;
    w = '0;
    for (int l = 0; l < LANES; l++) w[l*8] = ~mine;
    return w;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rvalid <= 1'b0;
      b_rvalid <= 1'b0;
      a_rdata  <= '0;
      b_rdata  <= '0;
    end else begin
      a_rvalid <= cmd_a.sem_rd;
      b_rvalid <= cmd_b.sem_rd;
      if (cmd_a.sem_rd) a_rdata <= flag_word(own[idx_a] == OWN_A);
      if (cmd_b.sem_rd) b_rdata <= flag_word(own[idx_b] == OWN_B);
    end
  end

  // R2
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_cs_n && !a_sem_n) |=> !a_rvalid);
  // R8
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cs_n && !a_sem_n && a_rw_n && !a_oe_n) |=> a_rvalid);
endmodule

// File: tb/sim_dp_signal_hub.sv
module sim_dp_signal_hub;
  localparam int AW = 14;
  localparam int DW = 32;
  localparam logic [AW-1:0] TOPA = '1;
  localparam logic [AW-1:0] CLRA = TOPA - 1'b1;

  logic clk = 0, rst_n = 0;
  logic a_cs_n = 1, a_sem_n = 1, a_rw_n = 1, a_oe_n = 1;
  logic b_cs_n = 1, b_sem_n = 1, b_rw_n = 1, b_oe_n = 1;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_rvalid, b_rvalid, a_irq, b_irq;

  always #5 clk = ~clk;

  dp_signal_hub u0 (.*);

  int n_chk = 0, n_bad = 0;
  int own_m [8];
  bit ra_m [8], rb_m [8];
  bit irqa_m, irqb_m, rva_m, rvb_m;
  logic [DW-1:0] rda_m, rdb_m;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input bit mine);
    return mine ? 32'h0 : 32'h0101_0101;
  endfunction

  // Drive both ports, advance the model and compare after the edge.
  task automatic step(input logic acs, asem, arw, aoe, input logic [AW-1:0] aad, input logic [DW-1:0] awd,
                      input logic bcs, bsem, brw, boe, input logic [AW-1:0] bad, input logic [DW-1:0] bwd,
                      input string tag);
    bit swa, swb, sra, srb, va, vb, seta, setb, clra, clrb;
    int fa, fb;
    a_cs_n = acs; a_sem_n = asem; a_rw_n = arw; a_oe_n = aoe; a_addr = aad; a_wdata = awd;
    b_cs_n = bcs; b_sem_n = bsem; b_rw_n = brw; b_oe_n = boe; b_addr = bad; b_wdata = bwd;
    swa = acs && !asem && !arw;  sra = acs && !asem && arw && !aoe;
    swb = bcs && !bsem && !brw;  srb = bcs && !bsem && brw && !boe;
    va = awd[0] & awd[8] & awd[16] & awd[24];
    vb = bwd[0] & bwd[8] & bwd[16] & bwd[24];
    seta = !acs && asem && !arw && aad == TOPA;
    setb = !bcs && bsem && !brw && bad == TOPA;
    clra = !acs && asem && arw && !aoe && aad == CLRA;
    clrb = !bcs && bsem && brw && !boe && bad == CLRA;
    fa = int'(aad[2:0]); fb = int'(bad[2:0]);
    rva_m = sra; rvb_m = srb;
    if (sra) rda_m = word_of(own_m[fa] == 1);
    if (srb) rdb_m = word_of(own_m[fb] == 2);
    if (swa) ra_m[fa] = !va;
    if (swb) rb_m[fb] = !vb;
    for (int f = 0; f < 8; f++) begin
      if (own_m[f] == 1 && !ra_m[f]) own_m[f] = 0;
      if (own_m[f] == 2 && !rb_m[f]) own_m[f] = 0;
      if (own_m[f] == 0) own_m[f] = ra_m[f] ? 1 : (rb_m[f] ? 2 : 0);
    end
    irqb_m = seta || (irqb_m && !clrb);
    irqa_m = setb || (irqa_m && !clra);
    @(negedge clk);
    chk({tag, " R9 R10 a_irq"}, 32'(a_irq), 32'(irqa_m));
    chk({tag, " R9 R10 b_irq"}, 32'(b_irq), 32'(irqb_m));
    chk({tag, " R8 a_rvalid"}, 32'(a_rvalid), 32'(rva_m));
    chk({tag, " R8 b_rvalid"}, 32'(b_rvalid), 32'(rvb_m));
    if (rva_m) chk({tag, " R8 a_rdata"}, a_rdata, rda_m);
    if (rvb_m) chk({tag, " R8 b_rdata"}, b_rdata, rdb_m);
  endtask

  localparam logic [DW-1:0] REQ = 32'h0, REL = 32'hFFFF_FFFF;

  task automatic idle2(input string tag);
    step(1,1,1,1,'0,'0, 1,1,1,1,'0,'0, tag);
  endtask

  initial begin : watchdog
    #1500000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int f = 0; f < 8; f++) begin own_m[f] = 0; ra_m[f] = 0; rb_m[f] = 0; end
    irqa_m = 0; irqb_m = 0; rva_m = 0; rvb_m = 0; rda_m = '0; rdb_m = '0;
    #12;
    // R1 reset state
    chk("R1 a_irq", 32'(a_irq), 0);
    chk("R1 b_irq", 32'(b_irq), 0);
    chk("R1 a_rvalid", 32'(a_rvalid), 0);
    chk("R1 b_rvalid", 32'(b_rvalid), 0);
    rst_n = 1;
    @(negedge clk);
    // R1 flag 5 free: read by A returns 1s
    step(1,0,1,0,14'd5,'0, 1,1,1,1,'0,'0, "R1 free");
    // R5 tie on flag 2, then R8 reads from both sides
    step(1,0,0,1,14'd2,REQ, 1,0,0,1,14'd2,REQ, "R5 tie");
    step(1,0,1,0,14'd2,'0, 1,0,1,0,14'd2,'0, "R5 R4 read");
    // R7 B releases a flag it does not own
    step(1,1,1,1,'0,'0, 1,0,0,1,14'd2,REL, "R7 foreign rel");
    step(1,0,1,0,14'd2,'0, 1,1,1,1,'0,'0, "R7 read");
    // R6 B re-requests, A releases: handover
    step(1,1,1,1,'0,'0, 1,0,0,1,14'd2,REQ, "R6 pend");
    step(1,0,0,1,14'd2,REL, 1,1,1,1,'0,'0, "R6 release");
    step(1,0,1,0,14'd2,'0, 1,0,1,0,14'd2,'0, "R6 read");
    // R3 only lane 8 zero counts as a request
    step(1,0,0,1,14'd6,32'hFFFF_FEFF, 1,1,1,1,'0,'0, "R3 lane8");
    step(1,0,1,0,14'd6,'0, 1,1,1,1,'0,'0, "R3 read");
    // R2 both selects low: no flag, no strobe, no interrupt
    step(0,0,0,1,14'd3,REQ, 0,0,0,1,TOPA,REQ, "R2 illegal wr");
    step(0,0,1,0,14'd3,'0, 1,1,1,1,'0,'0, "R2 illegal rd");
    step(1,0,1,0,14'd3,'0, 1,1,1,1,'0,'0, "R2 check");
    // R9 doorbell A->B, then R10 set and clear together, then clear
    step(0,1,0,1,TOPA,'0, 1,1,1,1,'0,'0, "R9 ring");
    step(0,1,0,1,TOPA,'0, 0,1,1,0,CLRA,'0, "R10 set wins");
    step(1,1,1,1,'0,'0, 0,1,1,0,CLRA,'0, "R10 clear");
    step(1,1,1,1,'0,'0, 0,1,0,1,TOPA,'0, "R9 ring b->a");
    step(0,1,1,0,CLRA,'0, 1,1,1,1,'0,'0, "R10 clear a");
    idle2("R1 idle");
    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic c[2], s[2], r[2], o[2];
      logic [AW-1:0] ad[2];
      logic [DW-1:0] wd[2];
      for (int p = 0; p < 2; p++) begin
        int op;
        op = int'($urandom % 6);
        wd[p] = $urandom;
        if ($urandom % 2) wd[p] = wd[p] | 32'h0101_0101;
        ad[p] = AW'($urandom);
        o[p] = 1'($urandom);
        case (op)
          0: begin c[p] = 1; s[p] = 1; r[p] = 1; end
          1: begin c[p] = 1; s[p] = 0; r[p] = 0; end
          2: begin c[p] = 1; s[p] = 0; r[p] = 1; o[p] = 0; end
          3: begin c[p] = 0; s[p] = 1; r[p] = 0; if ($urandom % 2) ad[p] = TOPA; end
          4: begin c[p] = 0; s[p] = 1; r[p] = 1; o[p] = 0; if ($urandom % 2) ad[p] = CLRA; end
          default: begin c[p] = 0; s[p] = 0; r[p] = 1'($urandom); end
        endcase
      end
      step(c[0],s[0],r[0],o[0],ad[0],wd[0], c[1],s[1],r[1],o[1],ad[1],wd[1], "rand");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule